// File: doc/BRIEF.md
# Dual Binary Phase Code Generator

This block produces two independent binary phase codes for a pair of transmitted waveforms. For each code it also produces a delayed echo that models a target reflection. Every output is a one-bit phase select for the phase-modulation control of a carrier synthesizer. A value of 0 selects 0° carrier phase and a value of 1 selects 180°. The block emits one code bit (chip) per clock, so with a 16 ns clock the chip time is 16 ns.

The two sequences are written word by word into staging storage through a simple write port. While `run` is high the generator repeats the code periodically. A frame-start strobe marks chip 0 of the reference codes. Each echo is not a delay line. It replays the active sequence with a circular offset, so at chip k it shows bit (k − d) mod L of its own sequence and wraps around the code period. The staged sequences, the code length and the two echo offsets are all taken over together at a frame start. Edits made while the generator runs therefore never break a frame in progress.

Top module: `dual_phase_code_gen`

## Requirements
- R1: After reset all five outputs are 0, and both staged and active sequences are all zero.
- R2: While the generator is idle (`run` low), every output stays 0, including during writes.
- R3: While running, `tx_a`/`tx_b` advance by one chip per clock. At chip k of a frame, `tx_x` equals bit k of that sequence, where bit k of word w, bit i is chip w·WORD_W+i. A frame lasts `len_m1`+1 clocks.
- R4: Sequences A (`wr_sel`=0) and B (`wr_sel`=1) are stored and replayed independently.
- R5: At chip k, `echo_x` equals bit ((k − d) mod L) of the same sequence, where d is the offset for that echo and L is the frame length.
- R6: An echo offset greater than `len_m1` is treated as `len_m1`.
- R7: `frame_start` is high exactly on chip 0 of each frame, once per period, and frames follow each other with no gap while `run` stays high.
- R8: A write to a sequence during a frame takes effect at the next frame start, not within the current frame.
- R9: `len_m1`, `dly_a` and `dly_b` are sampled at a frame start and held for that whole frame.
- R10: A length of one chip (`len_m1`=0) gives a strobe on every clock, and both echoes equal their reference.
- R11: Driving `run` low stops the generator at the next clock edge, and all outputs become 0. Raising `run` again restarts at chip 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | High to generate codes periodically |
| wr_en | input | 1 | Write strobe for staging storage |
| wr_sel | input | 1 | 0 selects sequence A, 1 selects sequence B |
| wr_addr | input | $clog2(MAX_LEN/WORD_W) | Word address within the sequence |
| wr_data | input | WORD_W | Chips to store; bit i is chip addr·WORD_W+i |
| len_m1 | input | $clog2(MAX_LEN) | Code length minus one |
| dly_a | input | $clog2(MAX_LEN) | Echo A circular offset in chips |
| dly_b | input | $clog2(MAX_LEN) | Echo B circular offset in chips |
| tx_a | output | 1 | Reference code A phase select |
| tx_b | output | 1 | Reference code B phase select |
| echo_a | output | 1 | Circularly shifted code A phase select |
| echo_b | output | 1 | Circularly shifted code B phase select |
| frame_start | output | 1 | High on chip 0 of each frame |

## Verification
A corrupted chip counter shows up within one frame, either as a strobe in the wrong cycle or as a reference bit that does not match the expected pattern. A wrong wrap computation for an echo appears only on the chips where k < d, so the offsets are chosen to straddle that boundary, including d = L−1 and clamped values. Staging or latch errors show up on the first chip after a mid-frame write or configuration change, either in the rest of the current frame or on chip 0 of the next frame.

// File: rtl/dual_phase_code_gen.sv
module dual_phase_code_gen #(
  parameter int MAX_LEN = 1024,
  parameter int WORD_W  = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               run,
  input  logic                               wr_en,
  input  logic                               wr_sel,
  input  logic [$clog2(MAX_LEN/WORD_W)-1:0]  wr_addr,
  input  logic [WORD_W-1:0]                  wr_data,
  input  logic [$clog2(MAX_LEN)-1:0]         len_m1,
  input  logic [$clog2(MAX_LEN)-1:0]         dly_a,
  input  logic [$clog2(MAX_LEN)-1:0]         dly_b,
  output logic                               tx_a,
  output logic                               tx_b,
  output logic                               echo_a,
  output logic                               echo_b,
  output logic                               frame_start
);
  localparam int AW = $clog2(MAX_LEN);
  localparam int LW = $clog2(WORD_W);

  logic [MAX_LEN-1:0] stg_a, stg_b, seq_a, seq_b;
  logic               running;
  logic [AW-1:0]      idx, cur_len, cur_da, cur_db;
  logic [AW:0]        ea_w, eb_w;

  wire            last  = (idx == cur_len);
  wire            start = run && (!running || last);
  wire [AW-1:0]   da_in = (dly_a > len_m1) ? len_m1 : dly_a;
  wire [AW-1:0]   db_in = (dly_b > len_m1) ? len_m1 : dly_b;
  wire [AW-1:0]   wbase = {wr_addr, LW'(0)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_a   <= '0;
      stg_b   <= '0;
      seq_a   <= '0;
      seq_b   <= '0;
      running <= 1'b0;
      idx     <= '0;
      cur_len <= '0;
      cur_da  <= '0;
      cur_db  <= '0;
    end else begin
      if (wr_en) begin
        if (wr_sel) stg_b[wbase +: WORD_W] <= wr_data;
        else        stg_a[wbase +: WORD_W] <= wr_data;
      end
      if (start) begin
        seq_a   <= stg_a;
        seq_b   <= stg_b;
        cur_len <= len_m1;
        cur_da  <= da_in;
        cur_db  <= db_in;
        idx     <= '0;
        running <= 1'b1;
      end else if (!run) begin
        running <= 1'b0;
        idx     <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  always_comb begin
    if (idx >= cur_da) ea_w = {1'b0, idx} - {1'b0, cur_da};
    else               ea_w = {1'b0, idx} + {1'b0, cur_len} + (AW+1)'(1) - {1'b0, cur_da};
    if (idx >= cur_db) eb_w = {1'b0, idx} - {1'b0, cur_db};
    else               eb_w = {1'b0, idx} + {1'b0, cur_len} + (AW+1)'(1) - {1'b0, cur_db};
  end

  assign tx_a        = running & seq_a[idx];
  assign tx_b        = running & seq_b[idx];
  assign echo_a      = running & seq_a[ea_w[AW-1:0]];
  assign echo_b      = running & seq_b[eb_w[AW-1:0]];
  assign frame_start = running & (idx == '0);

  AST_CHIP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && run && !last) |=> (idx == AW'($past(idx) + 1'b1))); // R3
  AST_WRAP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && run && last) |=> frame_start); // R7
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!frame_start && !tx_a && !tx_b && !echo_a && !echo_b)); // R11
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start) |=> ($stable(cur_len) && $stable(cur_da) && $stable(cur_db))); // R9
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start) |=> ($stable(seq_a) && $stable(seq_b))); // R8
  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cur_da <= cur_len && cur_db <= cur_len)); // R6
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (idx <= cur_len)); // R3
endmodule

// File: tb/dual_phase_code_gen_bench.sv
module dual_phase_code_gen_bench;
  localparam int MAX_LEN = 1024;
  localparam int WORD_W  = 8;
  localparam int AW      = $clog2(MAX_LEN);
  localparam int WAW     = $clog2(MAX_LEN/WORD_W);

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [WAW-1:0] wr_addr = '0;
  logic [WORD_W-1:0] wr_data = '0;
  logic [AW-1:0] len_m1 = '0, dly_a = '0, dly_b = '0;
  logic tx_a, tx_b, echo_a, echo_b, frame_start;

  dual_phase_code_gen #(.MAX_LEN(MAX_LEN), .WORD_W(WORD_W)) u_dual_phase_code_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_addr(wr_addr), .wr_data(wr_data), .len_m1(len_m1), .dly_a(dly_a),
    .dly_b(dly_b), .tx_a(tx_a), .tx_b(tx_b), .echo_a(echo_a), .echo_b(echo_b),
    .frame_start(frame_start));

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [4:0] exp_q[$];
  string tag_q[$];
  bit ma[MAX_LEN], mb[MAX_LEN], na[MAX_LEN], nb[MAX_LEN];

  function automatic logic [4:0] outs();
    return {frame_start, tx_a, tx_b, echo_a, echo_b};
  endfunction

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act{fs,ta,tb,ea,eb}=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(outs(), e, t);
    end
  end

  task automatic push_frame(input int L, input int da, input int db, input bit nxt, input string tag);
    int ca, cb;
    ca = (da > L-1) ? L-1 : da;
    cb = (db > L-1) ? L-1 : db;
    for (int k = 0; k < L; k++) begin
      bit ta, tb, ea, eb;
      int ia, ib;
      ia = (k - ca + L) % L;
      ib = (k - cb + L) % L;
      ta = nxt ? na[k]  : ma[k];
      tb = nxt ? nb[k]  : mb[k];
      ea = nxt ? na[ia] : ma[ia];
      eb = nxt ? nb[ib] : mb[ib];
      exp_q.push_back({(k == 0), ta, tb, ea, eb});
      tag_q.push_back(tag);
    end
  endtask

  task automatic run_frames(input int nf, input int L1, input int da1, input int db1,
                            input int L2, input int da2, input int db2, input string tag);
    int total;
    @(negedge clk);
    run = 1'b1;
    @(posedge clk);
    total = L1 + (nf - 1) * L2;
    push_frame(L1, da1, db1, 1'b0, tag);
    for (int f = 1; f < nf; f++) push_frame(L2, da2, db2, 1'b1, tag);
    repeat (total) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(outs(), 5'b0, "R11 stop");
    ma = na;
    mb = nb;
  endtask

  task automatic write_word(input bit sel, input int w);
    logic [WORD_W-1:0] d;
    for (int i = 0; i < WORD_W; i++) d[i] = sel ? nb[w*WORD_W+i] : na[w*WORD_W+i];
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = WAW'(w); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input int L);
    for (int w = 0; w < (L + WORD_W - 1) / WORD_W; w++) begin
      write_word(1'b0, w);
      check(outs(), 5'b0, "R2 idle during write");
      write_word(1'b1, w);
    end
    ma = na;
    mb = nb;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < MAX_LEN; i++) begin
      ma[i] = 0; mb[i] = 0; na[i] = 0; nb[i] = 0;
    end
    repeat (3) @(negedge clk);
    check(outs(), 5'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(outs(), 5'b0, "R1 after reset");

    // R1: zero sequences replay as zero
    len_m1 = AW'(4);
    run_frames(1, 5, 0, 0, 5, 0, 0, "R1 zero content");

    // R3 R4 R5: independent patterns, length 13
    for (int i = 0; i < 13; i++) begin
      na[i] = ((i * 7 + 3) % 5) < 2;
      nb[i] = ((i * 5 + 1) % 3) == 0;
    end
    load(13);
    check(outs(), 5'b0, "R2 idle after load");
    len_m1 = AW'(12); dly_a = AW'(0); dly_b = AW'(5);
    run_frames(2, 13, 0, 5, 13, 0, 5, "R3/R4/R5/R7 base");

    dly_a = AW'(3); dly_b = AW'(12);
    run_frames(1, 13, 3, 12, 13, 3, 12, "R5 wrap offsets");

    // R6: offsets beyond length clamp to len_m1
    dly_a = AW'(20); dly_b = AW'(13);
    run_frames(1, 13, 20, 13, 13, 20, 13, "R6 clamp");

    // R8: mid-frame write applies from next frame
    dly_a = AW'(2); dly_b = AW'(7);
    for (int i = 0; i < 8; i++) na[i] = ~ma[i];
    nb[9] = ~mb[9];
    fork
      run_frames(2, 13, 2, 7, 13, 2, 7, "R8 staged write");
      begin
        repeat (4) @(negedge clk);
        write_word(1'b0, 0);
        write_word(1'b1, 1);
      end
    join

    // R9: length and offsets change mid-frame, take hold at next frame
    dly_a = AW'(1); dly_b = AW'(4);
    fork
      run_frames(2, 13, 1, 4, 7, 2, 6, "R9 config sampled");
      begin
        repeat (5) @(negedge clk);
        len_m1 = AW'(6); dly_a = AW'(2); dly_b = AW'(6);
      end
    join

    // R10: single-chip code
    len_m1 = AW'(0); dly_a = AW'(3); dly_b = AW'(0);
    run_frames(3, 1, 3, 0, 1, 3, 0, "R10 length one");

    // R11: restart begins at chip 0
    len_m1 = AW'(6); dly_a = AW'(5); dly_b = AW'(1);
    run_frames(1, 7, 5, 1, 7, 5, 1, "R11 restart");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule